// File: doc/BRIEF.md
# Four-Lane Complex Requantizer with Rounding and Saturation

This block narrows complex samples from a wide fixed-point format to a compact one before they are packed for streaming. Each clock it accepts four complex samples. Each real and imaginary component is a signed 25-bit word with 23 fractional bits, so it carries two integer bits of headroom. Each component is rounded to 15 fractional bits and then clamped into the signed 16-bit Q1.15 range. Values too large for Q1.15 therefore pin to the nearest limit and do not wrap around.

All eight components (four lanes times real and imaginary) pass through identical and independent two-stage pipelines. The first stage adds the rounding offset. The second stage drops the surplus fraction bits and applies the clamp. A single qualifier travels alongside the data, so each result appears exactly two clock edges after its input was accepted. The data registers load only on qualified samples, which keeps the outputs steady between results. The block has no state machine: its only control is the qualifier delay line, which has two states per stage, empty and loaded.

Top module: `cplx_requant_top`

## Requirements
- R1: For a component input x (signed 25-bit, 23 fractional bits) whose rounded value fits, the output is floor((x + 128) / 256) as a signed 16-bit word.
- R2: Rounding is round-half-up at the dropped 8 bits: x = 128 gives 1, x = 127 gives 0, x = -128 gives 0, x = -129 gives -1.
- R3: When the rounded value exceeds 32767 (for example x = 8388480 or x = 16777215), the output is 32767 (16'h7FFF).
- R4: When the rounded value is below -32768 (for example x = -8388737 or x = -16777216), the output is -32768 (16'h8000); x = -8388608 gives exactly -32768.
- R5: Each of the eight components is converted independently. Lane k occupies bits [25k+24:25k] of the input buses and bits [16k+15:16k] of the output buses, with the real part on the re buses and the imaginary part on the im buses.
- R6: out_vld is in_vld delayed by exactly two clock edges, and the data presented with out_vld belongs to the input accepted two edges earlier.
- R7: While rst_n is low, out_vld is 0 and both output data buses are 0.
- R8: Input samples presented with in_vld low are ignored: the output data buses hold their last value while out_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_vld | input | 1 | Input samples qualifier |
| in_re | input | 100 | Four real components, 25 bits each |
| in_im | input | 100 | Four imaginary components, 25 bits each |
| out_vld | output | 1 | Output samples qualifier |
| out_re | output | 64 | Four real Q1.15 results |
| out_im | output | 64 | Four imaginary Q1.15 results |

## Verification
Rounding and clamping can fall in the same cycle. A rounding carry can itself push a value past a limit, as with x = 8388480. In one accepted sample, one component can also be clamped while its neighbour is only rounded. The bench provokes both cases with single samples that mix positive clamping, negative clamping, half-way rounding and in-range values across the lanes and between the real and imaginary parts of one lane. A scoreboard judges every component of each result against a value it computes from the floor-and-clamp rule.

// File: rtl/cplx_requant_pkg.sv
package cplx_requant_pkg;
    localparam int LANES    = 4;
    localparam int IN_W     = 25;
    localparam int IN_FRAC  = 23;
    localparam int OUT_W    = 16;
    localparam int OUT_FRAC = 15;
    localparam int COMPS    = 2 * LANES;
    localparam int DROP     = IN_FRAC - OUT_FRAC;
    localparam int SUM_W    = IN_W + 1;
    localparam int SH_W     = SUM_W - DROP;

    typedef enum logic {
        SLOT_EMPTY  = 1'b0,
        SLOT_LOADED = 1'b1
    } slot_e;
endpackage

// File: rtl/cplx_requant_round.sv
module cplx_requant_round
    import cplx_requant_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [IN_W-1:0]         comp_in,
    output logic [SH_W-1:0]         scaled_q
);
    localparam logic [SUM_W-1:0] HALF_LSB = SUM_W'(1) << (DROP - 1);

    logic [SUM_W-1:0] sum_d;
    logic [SH_W-1:0]  scaled_d;

    always_comb begin
        sum_d    = {comp_in[IN_W-1], comp_in} + HALF_LSB;
        scaled_d = SH_W'($signed(sum_d) >>> DROP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            scaled_q <= '0;
        else if (load)
            scaled_q <= scaled_d;
    end
endmodule

// File: rtl/cplx_requant_clamp.sv
module cplx_requant_clamp
    import cplx_requant_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [SH_W-1:0]         scaled,
    output logic [OUT_W-1:0]        comp_out
);
    localparam logic signed [SH_W-1:0] HI = SH_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [SH_W-1:0] LO = -SH_W'(2 ** (OUT_W - 1));

    logic [OUT_W-1:0] clamp_d;

    always_comb begin
        if ($signed(scaled) > HI)
            clamp_d = HI[OUT_W-1:0];
        else if ($signed(scaled) < LO)
            clamp_d = LO[OUT_W-1:0];
        else
            clamp_d = scaled[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            comp_out <= '0;
        else if (load)
            comp_out <= clamp_d;
    end

    assert_pos_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && $signed(scaled) > HI) |=> comp_out == HI[OUT_W-1:0]);

    assert_neg_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && $signed(scaled) < LO) |=> comp_out == LO[OUT_W-1:0]);

    assert_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && $signed(scaled) <= HI && $signed(scaled) >= LO)
        |=> $signed(comp_out) == $signed($past(scaled)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(comp_out));
endmodule

// File: rtl/cplx_requant_vld_pipe.sv
module cplx_requant_vld_pipe
    import cplx_requant_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vld_in,
    output logic mid_vld,
    output logic vld_out
);
    slot_e stage1_q, stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= SLOT_EMPTY;
            stage2_q <= SLOT_EMPTY;
        end else begin
            stage1_q <= vld_in ? SLOT_LOADED : SLOT_EMPTY;
            stage2_q <= stage1_q;
        end
    end

    always_comb begin
        mid_vld = (stage1_q == SLOT_LOADED);
        vld_out = (stage2_q == SLOT_LOADED);
    end

    assert_latency_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vld_in |-> ##2 vld_out);

    assert_latency_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_in |-> ##2 !vld_out);
endmodule

// File: rtl/cplx_requant_top.sv
module cplx_requant_top
    import cplx_requant_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [LANES*IN_W-1:0]   in_re,
    input  logic [LANES*IN_W-1:0]   in_im,
    output logic                    out_vld,
    output logic [LANES*OUT_W-1:0]  out_re,
    output logic [LANES*OUT_W-1:0]  out_im
);
    logic                       mid_vld;
    logic [COMPS*IN_W-1:0]      comp_in_bus;
    logic [COMPS*OUT_W-1:0]     comp_out_bus;

    assign comp_in_bus = {in_im, in_re};
    assign out_re      = comp_out_bus[LANES*OUT_W-1:0];
    assign out_im      = comp_out_bus[COMPS*OUT_W-1:LANES*OUT_W];

    cplx_requant_vld_pipe u_vld (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_in  (in_vld),
        .mid_vld (mid_vld),
        .vld_out (out_vld)
    );

    for (genvar c = 0; c < COMPS; c++) begin : g_comp
        logic [SH_W-1:0] scaled;

        cplx_requant_round u_round (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (in_vld),
            .comp_in  (comp_in_bus[c*IN_W +: IN_W]),
            .scaled_q (scaled)
        );

        cplx_requant_clamp u_clamp (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (mid_vld),
            .scaled   (scaled),
            .comp_out (comp_out_bus[c*OUT_W +: OUT_W])
        );
    end

    assert_reset_R7: assert property (@(posedge clk)
        !rst_n |-> (!out_vld && out_re == '0 && out_im == '0));
endmodule

// File: tb/cplx_requant_tb.sv
module cplx_requant_top_tb_top;
    localparam int LANES = 4;
    localparam int IN_W  = 25;
    localparam int OUT_W = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_vld = 1'b0;
    logic [LANES*IN_W-1:0]  in_re = '0;
    logic [LANES*IN_W-1:0]  in_im = '0;
    logic                   out_vld;
    logic [LANES*OUT_W-1:0] out_re;
    logic [LANES*OUT_W-1:0] out_im;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [LANES*OUT_W-1:0] re;
        logic [LANES*OUT_W-1:0] im;
        string                  tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    cplx_requant_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .in_re(in_re), .in_im(in_im),
        .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
    );

    function automatic logic [OUT_W-1:0] ref_q(int x);
        longint s;
        s = (longint'(x) + 128) >>> 8;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s[OUT_W-1:0];
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, int re0, int re1, int re2, int re3,
                         int im0, int im1, int im2, int im3);
        exp_t e;
        int r[4];
        int m[4];
        r = '{re0, re1, re2, re3};
        m = '{im0, im1, im2, im3};
        @(negedge clk);
        for (int k = 0; k < LANES; k++) begin
            in_re[k*IN_W +: IN_W] = r[k][IN_W-1:0];
            in_im[k*IN_W +: IN_W] = m[k][IN_W-1:0];
            e.re[k*OUT_W +: OUT_W] = ref_q(r[k]);
            e.im[k*OUT_W +: OUT_W] = ref_q(m[k]);
        end
        e.tag = tag;
        in_vld = 1'b1;
        sb_q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_re  = {4{25'h0ABCDE}};
            in_im  = {4{25'h1F0F0F}};
        end
    endtask

    // Monitor / scoreboard
    logic [LANES*OUT_W-1:0] last_re = '0;
    logic [LANES*OUT_W-1:0] last_im = '0;
    logic                   prev_vld = 1'b0;

    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check("R6 out_vld delay", {63'd0, out_vld}, {63'd0, prev_vld});
            if (out_vld) begin
                if (sb_q.size() == 0) begin
                    check("R6 unexpected result", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.tag, " re"}, out_re, e.re);
                    check({e.tag, " im"}, out_im, e.im);
                end
                last_re = out_re;
                last_im = out_im;
            end else begin
                check("R8 hold re", out_re, last_re);
                check("R8 hold im", out_im, last_im);
            end
            prev_vld = in_vld;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        in_re = {4{25'h1555555}};
        in_vld = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 reset vld", {63'd0, out_vld}, 64'd0);
        check("R7 reset re", out_re, '0);
        check("R7 reset im", out_im, '0);
        in_vld = 1'b0;
        rst_n  = 1'b1;
        idle(2);

        drive("R1 mid values", 256, 1000, -5000, 300000, -256, 0, 77777, -1234567);
        idle(1);
        drive("R2 half-way", 128, 127, -128, -129, 383, 384, -384, -385);
        drive("R3 positive clamp", 8388480, 16777215, 8388479, 8388607,
              8388480, 9000000, 8388352, 12345678);
        drive("R4 negative clamp", -8388737, -16777216, -8388608, -8388736,
              -9999999, -8388609, -8388480, -16000000);
        drive("R5 mixed lanes", 8388480, -16777216, 128, 4095,
              -129, 16777215, -8388737, 1);
        idle(3);
        for (int i = 0; i < 40; i++) begin
            drive("R1 sweep", int'($urandom_range(0, 33554431)) - 16777216,
                  int'($urandom_range(0, 33554431)) - 16777216,
                  int'($urandom_range(0, 2000000)) - 1000000,
                  int'($urandom_range(0, 2000000)) - 1000000,
                  int'($urandom_range(0, 33554431)) - 16777216,
                  int'($urandom_range(0, 8000000)) - 4000000,
                  int'($urandom_range(0, 16777215)),
                  -int'($urandom_range(0, 16777216)));
            if (i % 7 == 3) idle(2);
        end
        idle(5);
        check("R6 scoreboard drained", 64'(sb_q.size()), 64'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule